// File: doc/BRIEF.md
# Capability Access Guard

This block checks one memory access per cycle against a 128-bit capability before the access may reach memory. A load, store or instruction-fetch unit gives it the capability that authorises the access, together with a separate tag bit, the kind of access, the effective byte address and the access length in bytes. One cycle later the block returns a result strobe. With the strobe come either a grant or a refusal, and a code that names the reason for the refusal.

An access is granted only when four conditions all hold: the tag is set, the capability is not sealed, it carries the right that matches the access kind, and the whole byte range of the access lies inside its bounds. Otherwise the block refuses the access. When more than one condition fails, the code reports the one with the highest rank. The capability's own address field (the cursor) plays no part in the check. The requester passes the effective address separately.

Capability layout, from the top bit down: bits 127:100 hold the exclusive upper bound, bits 99:72 the inclusive lower bound, bits 71:67 the object type, bits 66:64 the rights, and bits 63:0 the cursor. Both bounds are zero-extended to the address width.

Top module: `cap_access_guard`

## Requirements
- R1: Each cycle with `req_valid` high gives `rsp_valid` high on the next cycle. A cycle without a request gives `rsp_valid`, `rsp_grant` and `rsp_cause` all zero on the next cycle. Reset clears all three.
- R2: `rsp_grant` is high exactly when `rsp_valid` is high and no fault applies, and `rsp_cause` is then 0.
- R3: If `req_tag` is clear, the access is refused with cause 1, whatever the other fields hold. This includes the null capability (tag clear, all fields zero).
- R4: A capability is sealed when bit 71 (the top bit of the object type) is set. A tagged, sealed capability is refused with cause 2. Object type values with bit 71 clear do not seal.
- R5: Rights are bit 64 (load), bit 65 (store) and bit 66 (fetch). Kind codes are 0 load, 1 store, 2 fetch, and 3 is reserved and has no matching right. If the right for the kind is missing, the access is refused with cause 3.
- R6: The access is in bounds only when lower <= addr and addr + size <= upper. Otherwise it is refused with cause 4. An access that starts exactly at the lower bound, or that ends exactly at the upper bound, is granted.
- R7: The end address addr + size is formed one bit wider than the address. An access that would wrap past the top of the address space is therefore refused with cause 4.
- R8: When several faults apply, the cause reported is the first of tag (1), seal (2), right (3), bounds (4).
- R9: The cursor field (bits 63:0) has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present this cycle |
| req_tag | input | 1 | Validity tag of the capability |
| req_cap | input | 128 | Capability authorising the access |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| req_addr | input | 64 | Effective byte address |
| req_size | input | 5 | Access length in bytes |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_grant | output | 1 | Access allowed |
| rsp_cause | output | 3 | Fault code: 0 none, 1 tag, 2 seal, 3 right, 4 bounds |

## Verification
The bench places accesses exactly on the lower bound, exactly on the upper bound and one byte past it. A design with an off-by-one comparison or an inclusive upper bound would either refuse the first two or grant the third. It also sends an access near the top of the address space whose end wraps. A design with an end sum only as wide as the address would see a small end address and grant it. Further accesses fail several checks at once, to catch a wrong ranking order. Others alter only the cursor or only the low object-type bits, to catch a design that reads the wrong field.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;
  localparam int CAP_W   = 128;
  localparam int ADDR_W  = 64;
  localparam int PERM_W  = 3;
  localparam int OTYPE_W = 5;
  localparam int SIZE_W  = 5;
  localparam int KIND_W  = 2;
  localparam int CAUSE_W = 3;
  localparam int NFAULT  = 4;
  localparam int BND_W   = (ADDR_W - PERM_W - OTYPE_W) / 2;
  localparam int EXT_W   = ADDR_W + 1;

  typedef enum logic [KIND_W-1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_TAG    = 3'd1,
    CAUSE_SEAL   = 3'd2,
    CAUSE_PERM   = 3'd3,
    CAUSE_BOUNDS = 3'd4
  } fault_cause_e;

  // Fault flag slots, lowest index has the highest rank
  localparam int FL_TAG   = 0;
  localparam int FL_SEAL  = 1;
  localparam int FL_PERM  = 2;
  localparam int FL_BOUND = 3;

  typedef struct packed {
    logic [BND_W-1:0]   upper;
    logic [BND_W-1:0]   lower;
    logic [OTYPE_W-1:0] otype;
    logic [PERM_W-1:0]  rights;
    logic [ADDR_W-1:0]  cursor;
  } cap_fields_t;

  // End of the byte range, one bit wider than the address
  function automatic logic [EXT_W-1:0] range_end(input logic [ADDR_W-1:0] addr,
                                                 input logic [SIZE_W-1:0] size);
    return {1'b0, addr} + {{(EXT_W-SIZE_W){1'b0}}, size};
  endfunction

  function automatic logic range_inside(input logic [ADDR_W-1:0] addr,
                                        input logic [SIZE_W-1:0] size,
                                        input logic [BND_W-1:0]  lo,
                                        input logic [BND_W-1:0]  hi);
    logic [EXT_W-1:0] lo_x, hi_x, start_x;
    lo_x    = {{(EXT_W-BND_W){1'b0}}, lo};
    hi_x    = {{(EXT_W-BND_W){1'b0}}, hi};
    start_x = {1'b0, addr};
    return (start_x >= lo_x) && (range_end(addr, size) <= hi_x);
  endfunction

  function automatic fault_cause_e rank_to_cause(input int idx);
    case (idx)
      FL_TAG:   return CAUSE_TAG;
      FL_SEAL:  return CAUSE_SEAL;
      FL_PERM:  return CAUSE_PERM;
      default:  return CAUSE_BOUNDS;
    endcase
  endfunction
endpackage

// File: rtl/cap_decode.sv
module cap_decode
  import cap_chk_pkg::*;
(
  input  logic [CAP_W-1:0] cap_raw,
  output cap_fields_t      fields,
  output logic             sealed
);
  assign fields = cap_fields_t'(cap_raw);
  assign sealed = fields.otype[OTYPE_W-1];
endmodule

// File: rtl/cap_rule_eval.sv
module cap_rule_eval
  import cap_chk_pkg::*;
(
  input  logic              tag,
  input  cap_fields_t       fields,
  input  logic              sealed,
  input  logic [KIND_W-1:0] kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic [NFAULT-1:0] flags
);
  logic [PERM_W-1:0] right_hit;

  // One comparator per right: right i serves access kind i
  for (genvar i = 0; i < PERM_W; i++) begin : g_right
    assign right_hit[i] = fields.rights[i] && (kind == KIND_W'(i));
  end

  logic in_range;
  assign in_range = range_inside(addr, size, fields.lower, fields.upper);

  assign flags[FL_TAG]   = !tag;
  assign flags[FL_SEAL]  = sealed;
  assign flags[FL_PERM]  = !(|right_hit);
  assign flags[FL_BOUND] = !in_range;
endmodule

// File: rtl/cap_fault_rank.sv
module cap_fault_rank
  import cap_chk_pkg::*;
(
  input  logic [NFAULT-1:0]  flags,
  output logic [CAUSE_W-1:0] cause
);
  always_comb begin
    cause = CAUSE_NONE;
    // Scan from lowest rank to highest so the highest-ranked flag wins
    for (int i = NFAULT - 1; i >= 0; i--) begin
      if (flags[i]) cause = rank_to_cause(i);
    end
  end
endmodule

// File: rtl/cap_access_guard.sv
module cap_access_guard
  import cap_chk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_tag,
  input  logic [CAP_W-1:0]   req_cap,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SIZE_W-1:0]  req_size,
  output logic               rsp_valid,
  output logic               rsp_grant,
  output logic [CAUSE_W-1:0] rsp_cause
);
  cap_fields_t        fields;
  logic               sealed;
  logic [NFAULT-1:0]  flags;
  logic [CAUSE_W-1:0] cause_c;

  cap_decode u_decode (
    .cap_raw (req_cap),
    .fields  (fields),
    .sealed  (sealed)
  );

  cap_rule_eval u_rules (
    .tag    (req_tag),
    .fields (fields),
    .sealed (sealed),
    .kind   (req_kind),
    .addr   (req_addr),
    .size   (req_size),
    .flags  (flags)
  );

  cap_fault_rank u_rank (
    .flags (flags),
    .cause (cause_c)
  );

  // Named events for the assertions
  logic ev_tag_bad, ev_seal_bad, ev_perm_bad, ev_bound_bad;
  assign ev_tag_bad   = req_valid && flags[FL_TAG];
  assign ev_seal_bad  = req_valid && flags[FL_SEAL];
  assign ev_perm_bad  = req_valid && flags[FL_PERM];
  assign ev_bound_bad = req_valid && flags[FL_BOUND];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_cause <= CAUSE_NONE;
    end else if (req_valid) begin
      rsp_valid <= 1'b1;
      rsp_grant <= (cause_c == CAUSE_NONE);
      rsp_cause <= cause_c;
    end else begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_cause <= CAUSE_NONE;
    end
  end

  a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_grant && rsp_cause == CAUSE_NONE));
  a_r2_grant_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> (rsp_valid && rsp_cause == CAUSE_NONE));
  a_r2_fault_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != CAUSE_NONE) |-> !rsp_grant);
  a_r3_tag_first: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tag_bad |=> (rsp_cause == CAUSE_TAG));
  a_r4_seal_next: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_seal_bad && !ev_tag_bad) |=> (rsp_cause == CAUSE_SEAL));
  a_r5_perm_next: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_perm_bad && !ev_tag_bad && !ev_seal_bad) |=> (rsp_cause == CAUSE_PERM));
  a_r6_bound_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bound_bad && !ev_tag_bad && !ev_seal_bad && !ev_perm_bad)
      |=> (rsp_cause == CAUSE_BOUNDS && !rsp_grant));
  a_r8_all_clear_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && flags == '0) |=> rsp_grant);
endmodule

// File: tb/cap_access_guard_tb.sv
module cap_access_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_tag = 1'b0;
  logic [127:0] req_cap = '0;
  logic [1:0]   req_kind = '0;
  logic [63:0]  req_addr = '0;
  logic [4:0]   req_size = '0;
  logic         rsp_valid;
  logic         rsp_grant;
  logic [2:0]   rsp_cause;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_access_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .req_cap(req_cap), .req_kind(req_kind), .req_addr(req_addr),
    .req_size(req_size), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .rsp_cause(rsp_cause)
  );

  function automatic logic [127:0] mk_cap(input logic [27:0] hi, input logic [27:0] lo,
                                          input logic [4:0] ot, input logic [2:0] rt,
                                          input logic [63:0] cur);
    return {hi, lo, ot, rt, cur};
  endfunction

  // Independent model: {grant, cause}
  function automatic logic [3:0] model(input logic tg, input logic [127:0] c,
                                       input logic [1:0] k, input logic [63:0] a,
                                       input logic [4:0] s);
    logic [79:0] a_w, e_w, lo_w, hi_w;
    a_w  = {16'd0, a};
    e_w  = a_w + {75'd0, s};
    lo_w = {52'd0, c[99:72]};
    hi_w = {52'd0, c[127:100]};
    if (!tg)                     return 4'd1;
    if (c[71])                   return 4'd2;
    if (k == 2'd3 || !c[64 + k]) return 4'd3;
    if (a_w < lo_w || e_w > hi_w) return 4'd4;
    return 4'b1000;
  endfunction

  task automatic check(input string rq, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got grant=%0b cause=%0d, expected grant=%0b cause=%0d",
               rq, act[3], act[2:0], exp[3], exp[2:0]);
    end
  endtask

  task automatic send(input string rq, input logic tg, input logic [127:0] c,
                      input logic [1:0] k, input logic [63:0] a, input logic [4:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_tag = tg; req_cap = c; req_kind = k;
    req_addr = a; req_size = s;
    exp_q.push_back(model(tg, c, k, a, s));
    tag_q.push_back(rq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: samples shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (rsp_valid) begin
          if (exp_q.size() == 0) begin
            check("R1 unexpected strobe", {rsp_valid, 3'd0}, 4'd0);
          end else begin
            check(tag_q.pop_front(), {rsp_grant, rsp_cause}, exp_q.pop_front());
          end
        end else begin
          check("R1 idle outputs", {rsp_grant, rsp_cause}, 4'd0);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [27:0] LO = 28'h0001000;
  localparam logic [27:0] HI = 28'h0001040;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {rsp_valid, rsp_grant, rsp_cause[1:0]}, 4'd0);
    rst_n = 1'b1;
    idle(2);
    // R2 grants for each kind with its right
    send("R2 load grant",  1, mk_cap(HI, LO, 5'd0, 3'b001, 64'h0), 2'd0, 64'h1010, 5'd8);
    send("R2 store grant", 1, mk_cap(HI, LO, 5'd0, 3'b010, 64'h0), 2'd1, 64'h1020, 5'd4);
    send("R2 fetch grant", 1, mk_cap(HI, LO, 5'd0, 3'b100, 64'h0), 2'd2, 64'h1000, 5'd4);
    idle(1);
    // R3 tag clear, everything else also bad
    send("R3 R8 tag over all", 0, mk_cap(HI, LO, 5'h10, 3'b000, 64'h0), 2'd1, 64'h9, 5'd8);
    send("R3 null capability", 0, 128'd0, 2'd0, 64'h0, 5'd0);
    // R4 sealing
    send("R4 R8 seal over perm", 1, mk_cap(HI, LO, 5'h10, 3'b000, 64'h0), 2'd0, 64'h1000, 5'd4);
    send("R4 low otype unsealed", 1, mk_cap(HI, LO, 5'h0F, 3'b001, 64'h0), 2'd0, 64'h1000, 5'd4);
    // R5 rights
    send("R5 R8 perm over bounds", 1, mk_cap(HI, LO, 5'd0, 3'b101, 64'h0), 2'd1, 64'h50, 5'd4);
    send("R5 fetch without right", 1, mk_cap(HI, LO, 5'd0, 3'b011, 64'h0), 2'd2, 64'h1000, 5'd4);
    send("R5 reserved kind", 1, mk_cap(HI, LO, 5'd0, 3'b111, 64'h0), 2'd3, 64'h1000, 5'd4);
    idle(2);
    // R6 bounds edges
    send("R6 below lower", 1, mk_cap(HI, LO, 5'd0, 3'b001, 64'h0), 2'd0, 64'h0FFF, 5'd1);
    send("R6 at lower",    1, mk_cap(HI, LO, 5'd0, 3'b001, 64'h0), 2'd0, 64'h1000, 5'd1);
    send("R6 end at upper", 1, mk_cap(HI, LO, 5'd0, 3'b001, 64'h0), 2'd0, 64'h1038, 5'd8);
    send("R6 one past upper", 1, mk_cap(HI, LO, 5'd0, 3'b001, 64'h0), 2'd0, 64'h1039, 5'd8);
    send("R6 zero size at upper", 1, mk_cap(HI, LO, 5'd0, 3'b001, 64'h0), 2'd0, 64'h1040, 5'd0);
    // R7 wrap past top of address space
    send("R7 wrapping access", 1, mk_cap(28'hFFFFFFF, 28'h0, 5'd0, 3'b001, 64'h0), 2'd0,
         64'hFFFF_FFFF_FFFF_FFFC, 5'd8);
    idle(1);
    // R9 cursor has no effect
    send("R9 cursor ignored grant", 1, mk_cap(HI, LO, 5'd0, 3'b001, 64'hDEAD_0000_0000_0000),
         2'd0, 64'h1010, 5'd8);
    send("R9 cursor ignored fault", 1, mk_cap(HI, LO, 5'd0, 3'b001, 64'h0000_0000_0000_1010),
         2'd0, 64'h2000, 5'd8);
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: got %0d missing results, expected 0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule